// File: doc/BRIEF.md
# Daisy-Chain Bus Arbiter

This block decides which of several devices on one shared I/O bus may use it. Every live device that wants the bus adds its request to one common wired-OR request line. A central controller answers with one grant pulse. That pulse enters the chain at device 0 and moves from device to device. A device that is not asking for the bus passes the pulse on. The first device that is asking keeps it and becomes the bus owner.

Because of this, priority depends only on where a device sits in the chain. The device closest to the controller always wins a contest, so devices farther down can be starved. A device marked as failed neither takes the grant nor passes it on, which cuts off every device after it.

The owner keeps the bus until it pulses its own release input. The controller then waits one idle cycle. After that it issues a new grant if any live request is still pending. The owner is held in a register, and the owner's index is an output, so exactly one owner can be observed at any time.

Top module: `daisy_bus_arbiter`

## Requirements
- R1: After reset there is no owner: `ownerValid`=0, `ownerIdx`=0, `devOwn`=0. `grantLine`=0.
- R2: When the block is idle and any device `i` has `devReq[i]`=1 with `devFailed[i]`=0, `grantLine` goes high after the next clock edge. It stays high for exactly one cycle.
- R3: The grant is taken by the lowest-index device that has a request, provided no failed device sits before it. Index 0 is closest to the controller and has the highest priority. This device owns the bus after the clock edge that ends the grant cycle.
- R4: `devGrantIn[0]` equals `grantLine`. The grant reaches cell `i+1` only if it reached cell `i`, and cell `i` neither requests nor has failed.
- R5: At most one bit of `devOwn` is set. When `ownerValid`=1, `ownerIdx` is the index of that bit. Ownership does not change until the owner releases.
- R6: A pulse on `devRelease` from a device that is not the owner has no effect.
- R7: When the owner asserts its `devRelease` bit, ownership clears at the next edge and one idle cycle follows. A new grant is issued after that only if a live request is pending.
- R8: A device that starts requesting while another device owns the bus does not take over. It competes only at the next grant.
- R9: A failed device blocks the grant for every device after it. If no device takes the grant, the block returns to idle with no owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| devReq | input | NUM_DEV | Bus request from each device |
| devRelease | input | NUM_DEV | End-of-tenure pulse from each device |
| devFailed | input | NUM_DEV | Device is dead: it neither takes nor passes the grant |
| grantLine | output | 1 | Grant pulse sent into the head of the chain |
| devGrantIn | output | NUM_DEV | Grant arriving at each cell |
| devOwn | output | NUM_DEV | Registered ownership flag for each device |
| ownerValid | output | 1 | Some device owns the bus |
| ownerIdx | output | $clog2(NUM_DEV) | Index of the owning device |

## Verification
The bench builds the block with five devices. With five devices, random request patterns regularly leave the winner at the far end of the chain. A short chain also lets a single random failed cell block a large share of the devices behind it. Directed sequences cover a non-owner release, a late upstream request during someone else's tenure, and a failed cell in front of the only requester. Random traffic compares the grant taps and the owner every cycle with a model of the chain held in the bench.

// File: rtl/daisy_arb_pkg.sv
package daisy_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_OWNED = 2'd2
  } arbState_t;

  typedef struct packed {
    logic grantPulse;
    logic clearOwner;
  } arbStrobe_t;
endpackage

// File: rtl/chain_cell.sv
module chain_cell (
  input  logic clk,
  input  logic rstN,
  input  logic grantIn,
  input  logic reqIn,
  input  logic failedIn,
  input  logic releaseIn,
  input  logic clearOwner,
  output logic grantOut,
  output logic takeOut,
  output logic releaseOut,
  output logic ownOut
);
  logic ownQ;

  always_comb begin
    takeOut    = grantIn & reqIn & ~failedIn;
    grantOut   = grantIn & ~reqIn & ~failedIn;
    releaseOut = ownQ & releaseIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           ownQ <= 1'b0;
    else if (clearOwner) ownQ <= 1'b0;
    else if (takeOut)    ownQ <= 1'b1;
  end

  assign ownOut = ownQ;
endmodule

// File: rtl/chain_datapath.sv
module chain_datapath #(
  parameter int NUM_DEV = 8,
  localparam int IDXW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  daisy_arb_pkg::arbStrobe_t     strobe,
  input  logic [NUM_DEV-1:0]            devReq,
  input  logic [NUM_DEV-1:0]            devRelease,
  input  logic [NUM_DEV-1:0]            devFailed,
  output logic                          liveReq,
  output logic                          anyTaken,
  output logic                          releaseSeen,
  output logic [NUM_DEV-1:0]            devGrantIn,
  output logic [NUM_DEV-1:0]            devOwn,
  output logic                          ownerValid,
  output logic [IDXW-1:0]               ownerIdx
);
  logic [NUM_DEV:0]   chainTap;
  logic [NUM_DEV-1:0] takeVec;
  logic [NUM_DEV-1:0] relVec;

  assign chainTap[0] = strobe.grantPulse;

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_cell
    chain_cell u_cell (
      .clk        (clk),
      .rstN       (rstN),
      .grantIn    (chainTap[i]),
      .reqIn      (devReq[i]),
      .failedIn   (devFailed[i]),
      .releaseIn  (devRelease[i]),
      .clearOwner (strobe.clearOwner),
      .grantOut   (chainTap[i+1]),
      .takeOut    (takeVec[i]),
      .releaseOut (relVec[i]),
      .ownOut     (devOwn[i])
    );
  end

  assign devGrantIn  = chainTap[NUM_DEV-1:0];
  assign liveReq     = |(devReq & ~devFailed);
  assign anyTaken    = |takeVec;
  assign releaseSeen = |relVec;
  assign ownerValid  = |devOwn;

  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (devOwn[i]) ownerIdx = IDXW'(i);
    end
  end
endmodule

// File: rtl/arb_control.sv
module arb_control (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      liveReq,
  input  logic                      anyTaken,
  input  logic                      releaseSeen,
  output daisy_arb_pkg::arbStrobe_t strobe
);
  import daisy_arb_pkg::*;

  arbState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ARB_IDLE:  if (liveReq) stateD = ARB_GRANT;
      ARB_GRANT: stateD = anyTaken ? ARB_OWNED : ARB_IDLE;
      ARB_OWNED: if (releaseSeen) stateD = ARB_IDLE;
      default:   stateD = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ARB_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.grantPulse = (stateQ == ARB_GRANT);
    strobe.clearOwner = (stateQ == ARB_OWNED) && releaseSeen;
  end
endmodule

// File: rtl/daisy_bus_arbiter.sv
module daisy_bus_arbiter #(
  parameter int NUM_DEV = 8,
  localparam int IDXW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devReq,
  input  logic [NUM_DEV-1:0] devRelease,
  input  logic [NUM_DEV-1:0] devFailed,
  output logic               grantLine,
  output logic [NUM_DEV-1:0] devGrantIn,
  output logic [NUM_DEV-1:0] devOwn,
  output logic               ownerValid,
  output logic [IDXW-1:0]    ownerIdx
);
  daisy_arb_pkg::arbStrobe_t strobe;
  logic liveReq, anyTaken, releaseSeen;

  arb_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .liveReq     (liveReq),
    .anyTaken    (anyTaken),
    .releaseSeen (releaseSeen),
    .strobe      (strobe)
  );

  chain_datapath #(.NUM_DEV(NUM_DEV)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .devReq      (devReq),
    .devRelease  (devRelease),
    .devFailed   (devFailed),
    .liveReq     (liveReq),
    .anyTaken    (anyTaken),
    .releaseSeen (releaseSeen),
    .devGrantIn  (devGrantIn),
    .devOwn      (devOwn),
    .ownerValid  (ownerValid),
    .ownerIdx    (ownerIdx)
  );

  assign grantLine = strobe.grantPulse;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_DEV = 8,
  localparam int IDXW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DEV-1:0] devReq,
  input logic [NUM_DEV-1:0] devRelease,
  input logic               grantLine,
  input logic [NUM_DEV-1:0] devGrantIn,
  input logic [NUM_DEV-1:0] devOwn,
  input logic               ownerValid,
  input logic [IDXW-1:0]    ownerIdx
);
  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(devOwn)); // R5

  AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    grantLine |=> !grantLine); // R2

  AST_HOLD_TENURE: assert property (@(posedge clk) disable iff (!rstN)
    (ownerValid && !(|(devRelease & devOwn))) |=> $stable(devOwn)); // R6

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (ownerValid && |(devRelease & devOwn)) |=> (!ownerValid && !grantLine)); // R7

  AST_OWNER_SAW_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ownerValid) |-> ((($past(devGrantIn) >> ownerIdx) & 1) != 0)); // R3

  AST_OWNER_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ownerValid) |-> ((($past(devReq) >> ownerIdx) & 1) != 0)); // R8

  AST_NO_GRANT_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rstN)
    ownerValid |-> !grantLine); // R8
endmodule

bind daisy_bus_arbiter arb_checker #(.NUM_DEV(NUM_DEV)) u_chk (.*);

// File: tb/test_daisy_bus_arbiter.sv
module test_daisy_bus_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 5;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] devReq = '0, devRelease = '0, devFailed = '0;
  logic grantLine;
  logic [N-1:0] devGrantIn, devOwn;
  logic ownerValid;
  logic [IW-1:0] ownerIdx;

  int nChecks = 0, nFails = 0;
  int mState = 0;   // 0 idle, 1 grant, 2 owned
  int mOwner = -1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  daisy_bus_arbiter #(.NUM_DEV(N)) i_daisy_bus_arbiter (
    .clk(clk), .rstN(rstN), .devReq(devReq), .devRelease(devRelease),
    .devFailed(devFailed), .grantLine(grantLine), .devGrantIn(devGrantIn),
    .devOwn(devOwn), .ownerValid(ownerValid), .ownerIdx(ownerIdx));

  function automatic int pickWinner(logic [N-1:0] r, logic [N-1:0] f);
    for (int i = 0; i < N; i++) begin
      if (f[i]) return -1;
      if (r[i]) return i;
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] expTaps(bit g, logic [N-1:0] r, logic [N-1:0] f);
    logic [N-1:0] t;
    bit reach = g;
    for (int i = 0; i < N; i++) begin
      t[i] = reach;
      reach = reach && !r[i] && !f[i];
    end
    return t;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // apply inputs for one cycle, advance model, check after edge
  task automatic step(logic [N-1:0] r, logic [N-1:0] rel, logic [N-1:0] f, string tag);
    int ns = mState;
    devReq = r; devRelease = rel; devFailed = f;
    case (mState)
      0: if (|(r & ~f)) ns = 1;
      1: begin
           mOwner = pickWinner(r, f);
           ns = (mOwner >= 0) ? 2 : 0;
         end
      default: if (mOwner >= 0 && rel[mOwner]) begin ns = 0; mOwner = -1; end
    endcase
    mState = ns;
    @(posedge clk); #1;
    check({tag, " R5 ownerValid"}, ownerValid, mOwner >= 0);
    if (mOwner >= 0) begin
      check({tag, " R3 ownerIdx"}, ownerIdx, mOwner);
      check({tag, " R5 devOwn"}, devOwn, 1 << mOwner);
    end
    check({tag, " R2 grantLine"}, grantLine, mState == 1);
    check({tag, " R4 devGrantIn"}, devGrantIn, expTaps(mState == 1, r, f));
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 ownerValid", ownerValid, 0);
    check("R1 grantLine", grantLine, 0);
    check("R1 devOwn", devOwn, 0);
    check("R1 ownerIdx", ownerIdx, 0);
    rstN = 1'b1;
    @(negedge clk);

    // far-end single requester
    step(5'b10000, '0, '0, "R2 far");
    step(5'b10000, '0, '0, "R3 far");
    step(5'b10000, '0, '0, "R5 hold");
    step(5'b00000, 5'b10000, '0, "R7 rel");
    step(5'b00000, '0, '0, "R7 idle");
    // priority between 1 and 3
    step(5'b01010, '0, '0, "R3 pri");
    step(5'b01010, '0, '0, "R3 pri");
    check("R3 winner is 1", ownerIdx, 1);
    // non-owner release and late upstream request
    step(5'b01011, 5'b01001, '0, "R6 foreign rel");
    step(5'b01011, '0, '0, "R8 late");
    check("R8 owner unchanged", ownerIdx, 1);
    step(5'b01001, 5'b00010, '0, "R7 rel");
    step(5'b01001, '0, '0, "R7 regrant");
    step(5'b01001, '0, '0, "R8 next");
    check("R8 device0 wins next", ownerIdx, 0);
    step(5'b01000, 5'b00001, '0, "R7 rel");
    step(5'b01000, '0, '0, "R2");
    step(5'b00000, '0, '0, "R3");
    step(5'b00000, 5'b01000, '0, "R7");
    // failed cell in front of requester
    step(5'b00100, '0, 5'b00010, "R9 blk");
    step(5'b00100, '0, 5'b00010, "R9 grant");
    step(5'b00100, '0, 5'b00010, "R9 none");
    check("R9 no owner", ownerValid, 0);
    step(5'b00000, '0, '0, "R9 idle");
    step(5'b00000, '0, '0, "R9 idle");

    // constrained random
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] r, rel, f;
      r = N'($urandom) & N'($urandom);
      f = (($urandom % 10) == 0) ? N'(1 << ($urandom % N)) : '0;
      rel = '0;
      if (mOwner >= 0 && ($urandom % 4) == 0) rel[mOwner] = 1'b1;
      if (($urandom % 8) == 0) rel = rel | N'($urandom);
      step(r, rel, f, "rand");
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule